// File: doc/BRIEF.md
# ATA Disk Interface Register Decoder

This block is the memory-mapped register front end of a two-drive ATA-style disk interface. A bus master issues single accesses into a 4 KiB window. Each access carries a byte address, a write flag and a width code of one, two or four bytes. Registers sit on a 16-byte stride: address bits [11:4] choose the register and bits [3:0] are not decoded. Data is right-aligned in the low lanes of the 32-bit data bus, in little-endian order.

The window holds the following registers:
- a data port;
- seven task-file registers;
- a status/control register, reachable at two indices;
- a 32-bit timing register;
- a 32-bit interrupt status word.

The drive behind the task file is modelled by a small storage stub. Two interrupt levels arrive, one from a DMA engine and one from the drive. Each is passed straight to its own output line and is also recorded in the interrupt status word. Software can acknowledge only the DMA flag in that word.

Reads return data one clock after the request, with a one-cycle valid strobe. An access to an unmapped register, or with a width that register does not accept, reads as all ones. If that access is a write, it changes nothing.

Top module: `ata_reg_front`

## Requirements
- R1: After reset the timing register and the interrupt status word read as zero, and `rd_valid` is low.
- R2: The data port is at index 0x00. It accepts reads of width code 0 (byte), 1 (16-bit) and 2 (32-bit), and writes of width code 1 and 2. A 16-bit write stores the value zero-extended. A byte read returns bits [7:0] of the stored value, a 16-bit read returns bits [15:0], and a 32-bit read returns all 32 bits.
- R3: A byte-wide write to the data port leaves its stored value unchanged.
- R4: Indices 0x01 to 0x07 are seven task-file byte registers, each reset to zero. Each stores a byte write and returns it, zero-extended, on a byte read. Accesses of any other width are ignored on write and read as 0xFFFFFFFF.
- R5: Indices 0x08 and 0x16 reach the same register, byte width only. A write sets the control byte. A read returns the status byte: 0x80 while control bit 2 is set, 0x50 otherwise.
- R6: Index 0x20 is the timing register. It is written and read only at width code 2, and address bits [3:0] do not change which register is reached.
- R7: In the interrupt status word at index 0x30, bit 31 follows the DMA input and bit 30 follows the drive input. Each bit is updated whenever its input changes level. All other bits read zero, and the word is readable only at width code 2.
- R8: A 32-bit write to index 0x30 with bit 31 set clears bit 31 and leaves bit 30 unchanged. Such a write without bit 31, or at any other width, has no effect. If the DMA input changes level in the same cycle as a clearing write, the new level wins.
- R9: `dma_irq_out` and `drv_irq_out` equal the DMA and drive interrupt inputs at all times.
- R10: A read of an unmapped index, or with width code 3, returns 0xFFFFFFFF. A write of that kind changes no register.
- R11: `rd_valid` is high for exactly the one cycle after each read request and stays low after writes and idle cycles. `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the window |
| req_size | input | 2 | Width code: 0 byte, 1 16-bit, 2 32-bit, 3 invalid |
| req_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| dma_irq_in | input | 1 | DMA interrupt level |
| drv_irq_in | input | 1 | Drive interrupt level |
| dma_irq_out | output | 1 | Forwarded DMA interrupt |
| drv_irq_out | output | 1 | Forwarded drive interrupt |

## Verification
The assertions check the following on every cycle:
- the read strobe timing;
- the all-ones answer to any rejected read;
- that the data port ignores byte writes;
- that the timing register holds its value when it is not written;
- that an input edge moves its interrupt flag;
- that an acknowledge clears only the top flag.

The value each register returns depends on earlier writes, so the bench's scenarios cover the rest:
- the data returned for each width;
- the aliasing of the status register and the effect of the control byte on it;
- the offset bits within a slot being ignored;
- the case where an input edge and an acknowledge fall in the same cycle.

// File: rtl/ata_reg_pkg.sv
package ata_reg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DATA,
        TGT_TASK,
        TGT_STAT,
        TGT_TIMING,
        TGT_IRQ
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic rd_ok;
        logic wr_ok;
    } dec_t;

    localparam int IDX_DATA   = 'h00;
    localparam int IDX_STAT_A = 'h08;
    localparam int IDX_STAT_B = 'h16;
    localparam int IDX_TIMING = 'h20;
    localparam int IDX_IRQ    = 'h30;

    localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

endpackage

// File: rtl/ata_reg_decode.sv
module ata_reg_decode
    import ata_reg_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int NUM_TF = 7,
    localparam int TF_W  = $clog2(NUM_TF)
) (
    input  logic [IDX_W-1:0] idx,
    input  acc_size_e        size,
    output dec_t             dec,
    output logic [TF_W-1:0]  tf_sel
);

    localparam logic [IDX_W-1:0] I_DATA   = IDX_W'(IDX_DATA);
    localparam logic [IDX_W-1:0] I_STAT_A = IDX_W'(IDX_STAT_A);
    localparam logic [IDX_W-1:0] I_STAT_B = IDX_W'(IDX_STAT_B);
    localparam logic [IDX_W-1:0] I_TIMING = IDX_W'(IDX_TIMING);
    localparam logic [IDX_W-1:0] I_IRQ    = IDX_W'(IDX_IRQ);
    localparam logic [IDX_W-1:0] I_TF_LO  = IDX_W'(1);
    localparam logic [IDX_W-1:0] I_TF_HI  = IDX_W'(NUM_TF);

    logic is_byte;
    logic is_word;

    always_comb begin
        is_byte = (size == SZ_BYTE);
        is_word = (size == SZ_WORD);
        tf_sel  = TF_W'(idx - I_TF_LO);
        dec     = '{tgt: TGT_NONE, rd_ok: 1'b0, wr_ok: 1'b0};
        if (idx == I_DATA) begin
            dec.tgt   = TGT_DATA;
            dec.rd_ok = (size != SZ_BAD);
            dec.wr_ok = (size == SZ_HALF) || is_word;
        end else if (idx >= I_TF_LO && idx <= I_TF_HI) begin
            dec.tgt   = TGT_TASK;
            dec.rd_ok = is_byte;
            dec.wr_ok = is_byte;
        end else if (idx == I_STAT_A || idx == I_STAT_B) begin
            dec.tgt   = TGT_STAT;
            dec.rd_ok = is_byte;
            dec.wr_ok = is_byte;
        end else if (idx == I_TIMING) begin
            dec.tgt   = TGT_TIMING;
            dec.rd_ok = is_word;
            dec.wr_ok = is_word;
        end else if (idx == I_IRQ) begin
            dec.tgt   = TGT_IRQ;
            dec.rd_ok = is_word;
            dec.wr_ok = is_word;
        end
    end

endmodule

// File: rtl/ata_drive_stub.sv
module ata_drive_stub
    import ata_reg_pkg::*;
#(
    parameter int          NUM_TF      = 7,
    parameter logic [7:0]  STATUS_IDLE = 8'h50,
    parameter logic [7:0]  STATUS_BUSY = 8'h80,
    parameter int          CTRL_RST_BIT = 2,
    localparam int         TF_W        = $clog2(NUM_TF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic            wr_ok,
    input  tgt_e            tgt,
    input  acc_size_e       size,
    input  logic [TF_W-1:0] tf_sel,
    input  logic [31:0]     wdata,
    output logic [31:0]     rd_word
);

    typedef struct packed {
        logic [31:0]             data;
        logic [7:0]              ctrl;
        logic [NUM_TF-1:0][7:0]  tf;
    } stub_t;

    stub_t st_d, st_q;
    logic  wr_en;

    always_comb begin
        st_d  = st_q;
        wr_en = wr_req && wr_ok;
        if (wr_en) begin
            unique case (tgt)
                TGT_DATA: st_d.data = (size == SZ_HALF) ? {16'h0, wdata[15:0]} : wdata;
                TGT_TASK: st_d.tf[tf_sel] = wdata[7:0];
                TGT_STAT: st_d.ctrl = wdata[7:0];
                default:  ;
            endcase
        end
        unique case (tgt)
            TGT_DATA: begin
                unique case (size)
                    SZ_BYTE: rd_word = {24'h0, st_q.data[7:0]};
                    SZ_HALF: rd_word = {16'h0, st_q.data[15:0]};
                    default: rd_word = st_q.data;
                endcase
            end
            TGT_TASK: rd_word = {24'h0, st_q.tf[tf_sel]};
            TGT_STAT: rd_word = {24'h0, st_q.ctrl[CTRL_RST_BIT] ? STATUS_BUSY : STATUS_IDLE};
            default:  rd_word = ALL_ONES;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DATA_BYTE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && tgt == TGT_DATA && size == SZ_BYTE) |=> $stable(st_q.data)); // R3

endmodule

// File: rtl/ata_irq_status.sv
module ata_irq_status #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               clr_top,
    output logic [31:0]        status
);

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] flag;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_lvl;
        if (clr_top) st_d.flag[0] = 1'b0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (src_lvl[n] != st_q.prev[n]) st_d.flag[n] = src_lvl[n];
        end
        status = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            status[31-n] = st_q.flag[n];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DMA_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_lvl[0]) |=> status[31]); // R7
    AST_DRV_FALL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(src_lvl[1]) |=> !status[30]); // R7
    AST_ACK_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_top && src_lvl[0] == st_q.prev[0]) |=> !status[31]); // R8
    AST_ACK_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_top && src_lvl[1] == st_q.prev[1]) |=> status[30] == $past(status[30])); // R8

endmodule

// File: rtl/ata_reg_front.sv
module ata_reg_front
    import ata_reg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int STRIDE_LOG2 = 4,
    parameter int NUM_TF      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              dma_irq_in,
    input  logic              drv_irq_in,
    output logic              dma_irq_out,
    output logic              drv_irq_out
);

    localparam int IDX_W = ADDR_W - STRIDE_LOG2;
    localparam int TF_W  = $clog2(NUM_TF);

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
        logic [31:0] timing;
    } front_t;

    front_t          st_d, st_q;
    dec_t            dec;
    acc_size_e       size;
    logic [TF_W-1:0] tf_sel;
    logic [31:0]     stub_word;
    logic [31:0]     irq_word;
    logic            rd_req, wr_req, wr_hit, clr_top;
    logic            unused_addr_lo;
    logic [31:0]     rd_mux;

    assign size           = acc_size_e'(req_size);
    assign unused_addr_lo = ^req_addr[STRIDE_LOG2-1:0];
    assign dma_irq_out    = dma_irq_in;
    assign drv_irq_out    = drv_irq_in;

    ata_reg_decode #(.IDX_W(IDX_W), .NUM_TF(NUM_TF)) i_decode (
        .idx    (req_addr[ADDR_W-1:STRIDE_LOG2]),
        .size   (size),
        .dec    (dec),
        .tf_sel (tf_sel)
    );

    ata_drive_stub #(.NUM_TF(NUM_TF)) i_stub (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .wr_ok   (dec.wr_ok),
        .tgt     (dec.tgt),
        .size    (size),
        .tf_sel  (tf_sel),
        .wdata   (req_wdata),
        .rd_word (stub_word)
    );

    ata_irq_status #(.NUM_SRC(2)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl ({drv_irq_in, dma_irq_in}),
        .clr_top (clr_top),
        .status  (irq_word)
    );

    always_comb begin
        rd_req  = req_valid && !req_write;
        wr_req  = req_valid && req_write;
        wr_hit  = wr_req && dec.wr_ok;
        clr_top = wr_hit && dec.tgt == TGT_IRQ && req_wdata[31];
        unique case (dec.tgt)
            TGT_DATA, TGT_TASK, TGT_STAT: rd_mux = stub_word;
            TGT_TIMING:                   rd_mux = st_q.timing;
            TGT_IRQ:                      rd_mux = irq_word;
            default:                      rd_mux = ALL_ONES;
        endcase
        st_d        = st_q;
        st_d.rvalid = rd_req;
        if (rd_req) st_d.rdata = dec.rd_ok ? rd_mux : ALL_ONES;
        if (wr_hit && dec.tgt == TGT_TIMING) st_d.timing = req_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rvalid;
    assign rd_data  = st_q.rdata;

    AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid); // R11
    AST_NO_STROBE_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid); // R11
    AST_REJECTED_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !dec.rd_ok) |=> rd_data == ALL_ONES); // R10
    AST_TIMING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && dec.tgt == TGT_TIMING) |=> $stable(st_q.timing)); // R6

endmodule

// File: tb/test_ata_reg_front.sv
module test_ata_reg_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        dma_irq_in = 1'b0;
    logic        drv_irq_in = 1'b0;
    logic        dma_irq_out;
    logic        drv_irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ata_reg_front i_ata_reg_front (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dma_irq_in(dma_irq_in), .drv_irq_in(drv_irq_in),
        .dma_irq_out(dma_irq_out), .drv_irq_out(drv_irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 2'd2, 32'hAABBCCDD, 32'h0,        4'd2},  // R2
        '{1'b0, 12'h000, 2'd2, 32'h0,        32'hAABBCCDD, 4'd2},  // R2
        '{1'b0, 12'h000, 2'd1, 32'h0,        32'h0000CCDD, 4'd2},  // R2
        '{1'b0, 12'h000, 2'd0, 32'h0,        32'h000000DD, 4'd2},  // R2
        '{1'b1, 12'h000, 2'd0, 32'h00000011, 32'h0,        4'd3},  // R3
        '{1'b0, 12'h000, 2'd2, 32'h0,        32'hAABBCCDD, 4'd3},  // R3
        '{1'b1, 12'h000, 2'd1, 32'hFFFF1234, 32'h0,        4'd2},  // R2
        '{1'b0, 12'h000, 2'd2, 32'h0,        32'h00001234, 4'd2},  // R2
        '{1'b1, 12'h030, 2'd0, 32'h0000005A, 32'h0,        4'd4},  // R4
        '{1'b0, 12'h030, 2'd0, 32'h0,        32'h0000005A, 4'd4},  // R4
        '{1'b1, 12'h030, 2'd1, 32'h0000FFFF, 32'h0,        4'd4},  // R4
        '{1'b0, 12'h030, 2'd0, 32'h0,        32'h0000005A, 4'd4},  // R4
        '{1'b0, 12'h030, 2'd2, 32'h0,        32'hFFFFFFFF, 4'd4},  // R4
        '{1'b1, 12'h070, 2'd0, 32'h00000077, 32'h0,        4'd4},  // R4
        '{1'b0, 12'h070, 2'd0, 32'h0,        32'h00000077, 4'd4},  // R4
        '{1'b0, 12'h010, 2'd0, 32'h0,        32'h00000000, 4'd4},  // R4
        '{1'b0, 12'h080, 2'd0, 32'h0,        32'h00000050, 4'd5},  // R5
        '{1'b1, 12'h160, 2'd0, 32'h00000004, 32'h0,        4'd5},  // R5
        '{1'b0, 12'h080, 2'd0, 32'h0,        32'h00000080, 4'd5},  // R5
        '{1'b0, 12'h160, 2'd0, 32'h0,        32'h00000080, 4'd5},  // R5
        '{1'b1, 12'h080, 2'd1, 32'h00000000, 32'h0,        4'd5},  // R5
        '{1'b0, 12'h160, 2'd0, 32'h0,        32'h00000080, 4'd5},  // R5
        '{1'b1, 12'h080, 2'd0, 32'h00000000, 32'h0,        4'd5},  // R5
        '{1'b0, 12'h160, 2'd0, 32'h0,        32'h00000050, 4'd5},  // R5
        '{1'b0, 12'h160, 2'd2, 32'h0,        32'hFFFFFFFF, 4'd5},  // R5
        '{1'b1, 12'h200, 2'd2, 32'hCAFEF00D, 32'h0,        4'd6},  // R6
        '{1'b0, 12'h200, 2'd2, 32'h0,        32'hCAFEF00D, 4'd6},  // R6
        '{1'b1, 12'h200, 2'd0, 32'h00000000, 32'h0,        4'd6},  // R6
        '{1'b0, 12'h20C, 2'd2, 32'h0,        32'hCAFEF00D, 4'd6},  // R6
        '{1'b0, 12'h200, 2'd1, 32'h0,        32'hFFFFFFFF, 4'd6},  // R6
        '{1'b0, 12'h400, 2'd2, 32'h0,        32'hFFFFFFFF, 4'd10}, // R10
        '{1'b1, 12'h090, 2'd0, 32'h00000033, 32'h0,        4'd10}, // R10
        '{1'b0, 12'h090, 2'd0, 32'h0,        32'hFFFFFFFF, 4'd10}, // R10
        '{1'b0, 12'h000, 2'd3, 32'h0,        32'hFFFFFFFF, 4'd10}, // R10
        '{1'b0, 12'h300, 2'd0, 32'h0,        32'hFFFFFFFF, 4'd7},  // R7
        '{1'b0, 12'hF00, 2'd2, 32'h0,        32'hFFFFFFFF, 4'd10}  // R10
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drives one access, samples at the next falling edge.
    task automatic op(input logic wr, input logic [11:0] addr, input logic [1:0] size,
                      input logic [31:0] wdata, input int req, input logic [31:0] exp);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = size;
        req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        chk(11, {31'h0, rd_valid}, {31'h0, !wr}); // R11
        if (!wr) chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(1, {31'h0, rd_valid}, 32'h0);                 // R1
        op(1'b0, 12'h200, 2'd2, 32'h0, 1, 32'h0);          // R1 timing reset
        op(1'b0, 12'h300, 2'd2, 32'h0, 1, 32'h0);          // R1 irq reset

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata,
               int'(VECS[i].req), VECS[i].exp);
        end
        @(negedge clk);
        chk(11, {31'h0, rd_valid}, 32'h0);                 // R11 idle

        // Interrupt scenarios
        dma_irq_in = 1'b1;
        #1 chk(9, {31'h0, dma_irq_out}, 32'h1);            // R9
        chk(9, {31'h0, drv_irq_out}, 32'h0);               // R9
        @(negedge clk);
        op(1'b0, 12'h300, 2'd2, 32'h0, 7, 32'h80000000);   // R7
        drv_irq_in = 1'b1;
        #1 chk(9, {31'h0, drv_irq_out}, 32'h1);            // R9
        @(negedge clk);
        op(1'b0, 12'h300, 2'd2, 32'h0, 7, 32'hC0000000);   // R7
        op(1'b1, 12'h300, 2'd2, 32'h80000000, 8, 32'h0);   // R8 ack
        op(1'b0, 12'h300, 2'd2, 32'h0, 8, 32'h40000000);   // R8
        op(1'b1, 12'h300, 2'd2, 32'h40000000, 8, 32'h0);   // R8 no bit 31
        op(1'b0, 12'h300, 2'd2, 32'h0, 8, 32'h40000000);   // R8
        dma_irq_in = 1'b0;
        @(negedge clk);
        op(1'b0, 12'h300, 2'd2, 32'h0, 7, 32'h40000000);   // R7
        dma_irq_in = 1'b1;                                 // edge and ack in one cycle
        op(1'b1, 12'h300, 2'd2, 32'h80000000, 8, 32'h0);   // R8
        op(1'b0, 12'h300, 2'd2, 32'h0, 8, 32'hC0000000);   // R8 new level wins
        drv_irq_in = 1'b0;
        @(negedge clk);
        op(1'b0, 12'h300, 2'd2, 32'h0, 7, 32'h80000000);   // R7
        op(1'b1, 12'h300, 2'd0, 32'h80000000, 8, 32'h0);   // R8 byte ack ignored
        op(1'b0, 12'h300, 2'd2, 32'h0, 8, 32'h80000000);   // R8
        op(1'b1, 12'h400, 2'd2, 32'hFFFFFFFF, 10, 32'h0);  // R10 unmapped write
        op(1'b0, 12'h200, 2'd2, 32'h0, 10, 32'hCAFEF00D);  // R10 timing intact
        op(1'b0, 12'h000, 2'd2, 32'h0, 10, 32'h00001234);  // R10 data intact

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule